// File: doc/BRIEF.md
# Peak-Current PWM Gate Modulator

This block produces the gate-drive bit for an external power switch that feeds an inductive load. A free-running period counter issues a tick at the start of every switching period; the gate turns on at that tick and stays on for at least a programmed minimum on-time. After that window, the gate turns off once a digital flag reports that the sensed load current has reached its reference. It then stays off until the next tick. If the flag never asserts, the gate stays on through period boundaries, so the duty cycle can reach 100%.

The over-reference flag comes from an analog comparator that is not part of this block, so it is treated as asynchronous and passed through a synchronizer chain before use. The period and minimum-on lengths are counts of system clocks. With a 100 MHz system clock, a 20 kHz switching rate is a period of 5000 and an 8% minimum on-time is 400; 25 kHz is a period of 4000. Dropping run enable turns the gate off and parks the period counter.

Top module: `cbc_pwm`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, gateOut is 0.
- R2: While runEn is 0, gateOut is 0 from the next clock edge on, and the period counter is held at zero. After runEn rises, the first gate turn-on happens exactly periodLen clock edges later.
- R3: While enabled, the gate turns on (gateOut = 1) at every period tick. Consecutive turn-ons are exactly periodLen clocks apart.
- R4: After each turn-on, gateOut stays 1 for at least minOnLen clocks, even if the over-reference flag is already asserted.
- R5: The over-reference input is synchronized through two flops. If it is high at clock edge n and the minimum window has elapsed, gateOut is 0 after edge n+2.
- R6: Once the gate has turned off within a period, it stays off until the next tick, even if the over-reference input falls again.
- R7: If the over-reference flag stays low, gateOut stays 1 across period boundaries (100% duty).
- R8: The period and minimum-on lengths are run-time settings. A new pair loaded while disabled sets both the turn-on spacing and the minimum on-width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run enable; 0 turns the gate off and parks the counter |
| overRefAsync | input | 1 | Asynchronous flag: sensed current is at or above the reference |
| periodLen | input | CNT_W | Switching period in clocks (at least 2) |
| minOnLen | input | CNT_W | Minimum on-time in clocks (at least 1) |
| gateOut | output | 1 | Gate-drive bit, 1 = switch on |

## Verification
The assertions assume that periodLen and minOnLen hold still while runEn is high. Changing either one mid-period could shift the minimum window after the control has already left it. They also assume periodLen is at least 2 and minOnLen is at least 1. The stimulus changes the settings only while the block is disabled. It drives the over-reference input at the falling clock edge, so the synchronizer samples a settled value. The random-pulse phase uses the same stable settings as the reference model it is compared against.

// File: rtl/cbc_pwm_pkg.sv
package cbc_pwm_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntHold;   // park the period counter at zero
  } ctrlStrb_t;

  // Status from datapath to control
  typedef struct packed {
    logic tick;        // start of a switching period
    logic windowDone;  // minimum on-time satisfied in this cycle
    logic trip;        // synchronized over-reference flag
  } dpFlags_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OFF    = 2'd1,
    ST_ON_MIN = 2'd2,
    ST_ON_REG = 2'd3
  } gateState_t;

endpackage

// File: rtl/cbc_pwm_datapath.sv
module cbc_pwm_datapath
  import cbc_pwm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             overRefAsync,
  input  logic [CNT_W-1:0] periodLen,
  input  logic [CNT_W-1:0] minOnLen,
  input  ctrlStrb_t        strb,
  output dpFlags_t         flags
);

  localparam int EXT_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [EXT_W-1:0] ONE_EXT = EXT_W'(1);

  logic [CNT_W-1:0]       periodCnt;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   tickInt;
  logic [EXT_W-1:0]       elapsedExt;

  // Synchronizer chain for the comparator flag
  generate
    if (SYNC_STAGES == 1) begin : g_syncOne
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= overRefAsync;
      end
    end else begin : g_syncChain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], overRefAsync};
      end
    end
  endgenerate

  assign tickInt    = !strb.cntHold && (periodCnt == (periodLen - ONE));
  assign elapsedExt = {1'b0, periodCnt} + ONE_EXT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            periodCnt <= '0;
    else if (strb.cntHold) periodCnt <= '0;
    else if (tickInt)      periodCnt <= '0;
    else                   periodCnt <= periodCnt + ONE;
  end

  always_comb begin
    flags.tick       = tickInt;
    flags.windowDone = (elapsedExt >= {1'b0, minOnLen});
    flags.trip       = syncQ[SYNC_STAGES-1];
  end

  // R2
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cntHold |=> (periodCnt == '0));

  // R3
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags.tick |=> (periodCnt == '0));

endmodule

// File: rtl/cbc_pwm_ctrl.sv
module cbc_pwm_ctrl
  import cbc_pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      runEn,
  input  dpFlags_t  flags,
  output ctrlStrb_t strb,
  output logic      gateOut
);

  gateState_t state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:   nextState = flags.tick ? ST_ON_MIN : ST_OFF;
      ST_OFF:    if (flags.tick) nextState = ST_ON_MIN;
      ST_ON_MIN: begin
        if (flags.tick)            nextState = ST_ON_MIN;
        else if (flags.windowDone) nextState = flags.trip ? ST_OFF : ST_ON_REG;
      end
      ST_ON_REG: begin
        if (flags.tick)      nextState = ST_ON_MIN;
        else if (flags.trip) nextState = ST_OFF;
      end
      default:   nextState = ST_IDLE;
    endcase
    if (!runEn) nextState = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    strb.cntHold = !runEn;
    gateOut      = (state == ST_ON_MIN) || (state == ST_ON_REG);
  end

  // R2
  disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> !gateOut);

  // R3
  tick_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.tick && runEn) |=> gateOut);

  // R4
  min_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gateOut && runEn && !flags.windowDone) |=> gateOut);

  // R5
  trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gateOut && flags.windowDone && flags.trip && !flags.tick) |=> !gateOut);

  // R6
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gateOut && !flags.tick) |=> !gateOut);

  // R7
  full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gateOut && runEn && !flags.trip) |=> gateOut);

endmodule

// File: rtl/cbc_pwm.sv
module cbc_pwm
  import cbc_pwm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             runEn,
  input  logic             overRefAsync,
  input  logic [CNT_W-1:0] periodLen,
  input  logic [CNT_W-1:0] minOnLen,
  output logic             gateOut
);

  ctrlStrb_t strb;
  dpFlags_t  flags;

  cbc_pwm_datapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .overRefAsync(overRefAsync),
    .periodLen   (periodLen),
    .minOnLen    (minOnLen),
    .strb        (strb),
    .flags       (flags)
  );

  cbc_pwm_ctrl i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .runEn  (runEn),
    .flags  (flags),
    .strb   (strb),
    .gateOut(gateOut)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> !gateOut);

endmodule

// File: tb/test_cbc_pwm.sv
module test_cbc_pwm;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        runEn;
  logic        overRef;
  logic [15:0] periodLen;
  logic [15:0] minOnLen;
  logic        gateOut;

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R1";

  // behavioural reference state
  int mCnt = 0;
  int mGate = 0;
  int mS1 = 0;
  int mS2 = 0;

  always #4 clk = ~clk;

  cbc_pwm #(.CNT_W(16), .SYNC_STAGES(2)) i_cbc_pwm (
    .clk         (clk),
    .rst_n       (rst_n),
    .runEn       (runEn),
    .overRefAsync(overRef),
    .periodLen   (periodLen),
    .minOnLen    (minOnLen),
    .gateOut     (gateOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    int trip;
    bit tk;
    bit dn;
    if (!rst_n) begin
      mCnt = 0; mGate = 0; mS1 = 0; mS2 = 0;
    end else begin
      trip = mS2;
      mS2  = mS1;
      mS1  = int'(overRef);
      if (!runEn) begin
        mCnt = 0; mGate = 0;
      end else begin
        tk = (mCnt == int'(periodLen) - 1);
        dn = (mCnt + 1 >= int'(minOnLen));
        if (tk) mGate = 1;
        else if (mGate == 1 && dn && trip == 1) mGate = 0;
        mCnt = tk ? 0 : mCnt + 1;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    chk(int'(gateOut) == mGate, {curReq, " model"}, int'(gateOut), mGate);
  end

  task automatic countWhile(input bit lvl, output int n);
    n = 0;
    while (gateOut == lvl && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int k;
    int w;
    int l;
    int h;
    rst_n = 1'b0; runEn = 1'b0; overRef = 1'b0;
    periodLen = 16'd40; minOnLen = 16'd4;
    repeat (4) @(negedge clk);
    chk(gateOut == 1'b0, "R1", int'(gateOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gateOut == 1'b0, "R1", int'(gateOut), 0);

    // R2: disabled, flag toggling has no effect
    curReq = "R2";
    for (int i = 0; i < 12; i++) begin
      overRef = i[0];
      @(negedge clk);
      chk(gateOut == 1'b0, "R2", int'(gateOut), 0);
    end
    overRef = 1'b0;
    repeat (3) @(negedge clk);
    runEn = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!gateOut && k < 200);
    chk(k == 40, "R2", k, 40);

    // R4 and R3: flag held high, width equals minimum window
    curReq = "R4";
    overRef = 1'b1;
    countWhile(1'b1, w);
    countWhile(1'b0, l);
    countWhile(1'b1, w);
    chk(w == 4, "R4", w, 4);
    countWhile(1'b0, l);
    curReq = "R3";
    chk(w + l == 40, "R3", w + l, 40);

    // R5 and R6: single pulse mid-period, then no retrigger
    curReq = "R5";
    overRef = 1'b0;
    countWhile(1'b1, w);
    countWhile(1'b0, l);
    repeat (15) @(negedge clk);
    chk(gateOut == 1'b1, "R5", int'(gateOut), 1);
    overRef = 1'b1;
    @(negedge clk);
    overRef = 1'b0;
    chk(gateOut == 1'b1, "R5", int'(gateOut), 1);
    @(negedge clk);
    chk(gateOut == 1'b1, "R5", int'(gateOut), 1);
    @(negedge clk);
    chk(gateOut == 1'b0, "R5", int'(gateOut), 0);
    curReq = "R6";
    countWhile(1'b0, l);
    chk(l == 22, "R6", l, 22);

    // R7: flag never set, gate stays on across boundaries
    curReq = "R7";
    h = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (gateOut) h++;
    end
    chk(h == 120, "R7", h, 120);

    // R2: disable drops the gate on the next edge
    curReq = "R2";
    runEn = 1'b0;
    @(negedge clk);
    chk(gateOut == 1'b0, "R2", int'(gateOut), 0);
    repeat (5) @(negedge clk);
    chk(gateOut == 1'b0, "R2", int'(gateOut), 0);

    // R8: new settings loaded while disabled
    curReq = "R8";
    periodLen = 16'd25; minOnLen = 16'd2;
    overRef = 1'b1;
    @(negedge clk);
    runEn = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!gateOut && k < 200);
    chk(k == 25, "R8", k, 25);
    countWhile(1'b1, w);
    chk(w == 2, "R8", w, 2);
    countWhile(1'b0, l);
    chk(w + l == 25, "R8", w + l, 25);

    // R5: random comparator pulses against the model
    curReq = "R5";
    for (int i = 0; i < 400; i++) begin
      overRef = (($urandom % 7) == 0);
      @(negedge clk);
    end
    overRef = 1'b0;
    repeat (4) @(negedge clk);

    finishRun();
  end

endmodule